// File: doc/BRIEF.md
# Transmit Buffer Window Selector

This block decides which of several transmit message buffers a CAN controller maps into its one shared host register window. Software writes a selection byte, usually a copy of the buffer-empty flags, and the block keeps only the lowest-numbered set bit among the selection bits. Reading the register back returns that single retained bit, so software can fetch "the next free buffer" with one read and one write.

From the stored selection and the per-buffer empty flags, the block derives a binary buffer index and a window-enable. Host accesses to the window are passed through only while a buffer is selected and that buffer is still empty, meaning it is not queued for sending. A denied access reads as zero and its write is dropped. A denied access also raises a one-cycle blocked strobe. The selection is forced to zero while the controller sits in initialization mode. Writes count only when initialization is fully off.

Top module: `txbuf_window_sel`

## Requirements
- R1: After a synchronous active-low reset, `reg_rdata` is 0, `win_en` is 0 and `win_blocked` is 0.
- R2: A register write in normal mode (`init_req`=0, `init_ack`=0) stores only the lowest-numbered set bit among `reg_wdata[2:0]`. Bits 7..3 of the write have no effect. Example: writing 0x06 stores 0b010.
- R3: `reg_rdata` returns the stored selection in bits 2..0 with bits 7..3 zero. Example: after a write of 0x06, the read value is 0x02.
- R4: A normal-mode write whose bits 2..0 are all zero clears the selection to 0, so no buffer is selected.
- R5: While `init_req`=1 and `init_ack`=1, the selection is cleared to 0 at the next clock edge and register writes have no effect.
- R6: While `init_req` and `init_ack` differ, register writes are ignored and the selection keeps its value.
- R7: `buf_idx` is 0 for selection 0b001 or for no selection, 1 for 0b010 and 2 for 0b100.
- R8: `win_en` is 1 exactly when a buffer is selected and its `tx_empty` bit is 1. `buf_we` equals `win_wr` AND `win_en`. `win_rdata` equals `buf_rdata` when `win_en` is 1 and 0 otherwise.
- R9: When `win_rd` or `win_wr` is high at a clock edge while `win_en` is 0, `win_blocked` is 1 for the following cycle. In every other case it is 0 for that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Selection register write strobe |
| reg_wdata | input | 8 | Selection register write data |
| reg_rdata | output | 8 | Selection register read data |
| init_req | input | 1 | Initialization mode request |
| init_ack | input | 1 | Initialization mode acknowledge |
| tx_empty | input | 3 | Per-buffer empty flags; 1 = free, 0 = queued |
| win_rd | input | 1 | Shared window read request |
| win_wr | input | 1 | Shared window write request |
| buf_rdata | input | 8 | Read data from the mapped buffer storage |
| win_rdata | output | 8 | Gated window read data |
| buf_we | output | 1 | Gated write enable to the buffer storage |
| buf_idx | output | 2 | Index of the selected buffer |
| win_en | output | 1 | Window access allowed |
| win_blocked | output | 1 | One-cycle strobe after a denied window access |

## Verification
The hardest cases to reach are the initialization handshake's transition states. In these, `init_req` and `init_ack` disagree, and a write must leave a non-zero selection untouched. The bench first loads a known selection. It then holds each mismatched pair of handshake inputs while issuing writes, and only afterwards enters full initialization to check the clear. Every write byte and every empty-flag pattern is also swept, so each selection is seen against both queued and free buffers.

// File: rtl/txsel_pkg.sv
// Shared sizing for the transmit buffer window selector.
// Assumes a byte-wide host register and a small number of buffers.
package txsel_pkg;
    localparam int TXSEL_NBUF   = 3;
    localparam int TXSEL_DATA_W = 8;
endpackage

// File: rtl/txsel_lowbit.sv
// Lowest-set-bit picker: keeps only the lowest-numbered 1 of its input.
// Assumes nothing about the input; an all-zero input yields all-zero.
module txsel_lowbit #(
    parameter int W = 3
) (
    input  logic [W-1:0] in_vec,
    output logic [W-1:0] out_vec
);
    logic [W:0] seen;   // seen[i]: some bit below i is set

    assign seen[0] = 1'b0;

    // Ripple chain marking positions above the first set bit.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign out_vec[i]  = in_vec[i] & ~seen[i];
        assign seen[i + 1] = seen[i] | in_vec[i];
    end

    always_comb begin
        assert (out_vec == (in_vec & (~in_vec + W'(1))))
            else $error("lowbit picker mismatch");
    end
endmodule

// File: rtl/txsel_selreg.sv
// Selection register: holds the one-hot buffer selection.
// Cleared in full initialization mode; written only in normal mode.
// Assumes pick_in is already reduced to a single set bit (or zero).
module txsel_selreg #(
    parameter int NBUF = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [NBUF-1:0] pick_in,
    input  logic            init_req,
    input  logic            init_ack,
    output logic [NBUF-1:0] sel
);
    logic in_init;
    logic in_run;

    assign in_init = init_req & init_ack;
    assign in_run  = ~init_req & ~init_ack;

    // Update the selection: reset, init clear, normal-mode write, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel <= '0;
        else if (in_init)
            sel <= '0;
        else if (in_run && wr)
            sel <= pick_in;
    end

    p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));
    p_init_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (init_req && init_ack) |=> (sel == '0));
    p_transition_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (init_req != init_ack) |=> $stable(sel));
    p_write_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_req && !init_ack && wr) |=> (sel == $past(pick_in)));
endmodule

// File: rtl/txsel_gate.sv
// Window gate: derives buffer index and enable from the selection and
// empty flags, gates window data/write, and strobes on denied accesses.
// Assumes sel is one-hot or zero.
module txsel_gate #(
    parameter int NBUF   = 3,
    parameter int DATA_W = 8,
    localparam int IDX_W = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NBUF-1:0]   sel,
    input  logic [NBUF-1:0]   tx_empty,
    input  logic              win_rd,
    input  logic              win_wr,
    input  logic [DATA_W-1:0] buf_rdata,
    output logic [DATA_W-1:0] win_rdata,
    output logic              buf_we,
    output logic [IDX_W-1:0]  buf_idx,
    output logic              win_en,
    output logic              win_blocked
);
    logic denied;

    // Encode the one-hot selection into a binary index (0 when none).
    always_comb begin
        buf_idx = '0;
        for (int i = 0; i < NBUF; i++) begin
            if (sel[i]) buf_idx = IDX_W'(i);
        end
    end

    assign win_en    = |(sel & tx_empty);
    assign buf_we    = win_wr & win_en;
    assign win_rdata = win_en ? buf_rdata : '0;
    assign denied    = (win_rd | win_wr) & ~win_en;

    // Register the denied-access strobe for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            win_blocked <= 1'b0;
        else
            win_blocked <= denied;
    end

    p_we_needs_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> (sel != '0 && tx_empty[buf_idx]));
    p_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == '0) |-> (win_rdata == '0 && !buf_we));
    p_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((win_rd || win_wr) && !win_en) |=> win_blocked);
    p_no_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !((win_rd || win_wr) && !win_en) |=> !win_blocked);
endmodule

// File: rtl/txbuf_window_sel.sv
// Transmit buffer window selector top: lowest-bit reduction of the host
// write, selection register, and window gating.
// Assumes reads of the selection register are combinational.
module txbuf_window_sel
    import txsel_pkg::*;
#(
    parameter int NBUF   = TXSEL_NBUF,
    parameter int DATA_W = TXSEL_DATA_W,
    localparam int IDX_W = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              init_req,
    input  logic              init_ack,
    input  logic [NBUF-1:0]   tx_empty,
    input  logic              win_rd,
    input  logic              win_wr,
    input  logic [DATA_W-1:0] buf_rdata,
    output logic [DATA_W-1:0] win_rdata,
    output logic              buf_we,
    output logic [IDX_W-1:0]  buf_idx,
    output logic              win_en,
    output logic              win_blocked
);
    logic [NBUF-1:0] pick;
    logic [NBUF-1:0] sel;
    logic            wr_unused_hi;

    assign wr_unused_hi = ^reg_wdata[DATA_W-1:NBUF];

    txsel_lowbit #(.W(NBUF)) u_lowbit (
        .in_vec  (reg_wdata[NBUF-1:0]),
        .out_vec (pick)
    );

    txsel_selreg #(.NBUF(NBUF)) u_selreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .pick_in  (pick),
        .init_req (init_req),
        .init_ack (init_ack),
        .sel      (sel)
    );

    txsel_gate #(.NBUF(NBUF), .DATA_W(DATA_W)) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel         (sel),
        .tx_empty    (tx_empty),
        .win_rd      (win_rd),
        .win_wr      (win_wr),
        .buf_rdata   (buf_rdata),
        .win_rdata   (win_rdata),
        .buf_we      (buf_we),
        .buf_idx     (buf_idx),
        .win_en      (win_en),
        .win_blocked (win_blocked)
    );

    assign reg_rdata = {{(DATA_W-NBUF){1'b0}}, sel};

    p_read_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DATA_W-1:NBUF] == '0);
endmodule

// File: tb/txbuf_window_sel_test.sv
module txbuf_window_sel_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       init_req = 1'b0;
    logic       init_ack = 1'b0;
    logic [2:0] tx_empty = '0;
    logic       win_rd = 1'b0;
    logic       win_wr = 1'b0;
    logic [7:0] buf_rdata = '0;
    logic [7:0] win_rdata;
    logic       buf_we;
    logic [1:0] buf_idx;
    logic       win_en;
    logic       win_blocked;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    txbuf_window_sel uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .init_req(init_req), .init_ack(init_ack),
        .tx_empty(tx_empty), .win_rd(win_rd), .win_wr(win_wr),
        .buf_rdata(buf_rdata), .win_rdata(win_rdata), .buf_we(buf_we),
        .buf_idx(buf_idx), .win_en(win_en), .win_blocked(win_blocked)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Issue one register write at a negedge; returns after the capturing edge.
    task automatic reg_write(input logic [7:0] v);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    function automatic logic [2:0] low_bit(input logic [2:0] v);
        return v & (~v + 3'd1);
    endfunction

    function automatic logic [1:0] idx_of(input logic [2:0] s);
        return s[2] ? 2'd2 : (s[1] ? 2'd1 : 2'd0);
    endfunction

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rdata", reg_rdata, 0);
        check("R1 win_en", win_en, 0);
        check("R1 blocked", win_blocked, 0);

        // Sweep every write byte and every empty-flag pattern.
        for (int v = 0; v < 256; v++) begin
            logic [2:0] exp_sel;
            exp_sel = low_bit(v[2:0]);
            reg_write(v[7:0]);
            check(v[2:0] == 0 ? "R4 cleared" : "R2 lowest bit", reg_rdata[2:0], exp_sel);
            check("R3 read value", reg_rdata, {5'b0, exp_sel});
            check("R7 index", buf_idx, idx_of(exp_sel));
            for (int e = 0; e < 8; e++) begin
                logic en_exp;
                @(negedge clk);
                tx_empty = e[2:0];
                buf_rdata = 8'hA5 ^ v[7:0];
                win_wr = 1'b1;
                #1;
                en_exp = |(exp_sel & e[2:0]);
                check("R8 win_en", win_en, en_exp);
                check("R8 buf_we", buf_we, en_exp);
                check("R8 win_rdata", win_rdata, en_exp ? (8'hA5 ^ v[7:0]) : 8'h00);
                win_wr = 1'b0;
            end
        end

        // R6: transition states ignore writes.
        reg_write(8'h04);
        check("R6 setup", reg_rdata, 4);
        @(negedge clk); init_req = 1'b1; init_ack = 1'b0;
        reg_write(8'h01);
        check("R6 req-only hold", reg_rdata, 4);
        @(negedge clk); init_req = 1'b0; init_ack = 1'b1;
        reg_write(8'h02);
        check("R6 ack-only hold", reg_rdata, 4);
        // R5: full init clears and ignores writes.
        @(negedge clk); init_req = 1'b1; init_ack = 1'b1;
        @(negedge clk);
        check("R5 init clear", reg_rdata, 0);
        reg_write(8'h02);
        check("R5 write ignored", reg_rdata, 0);
        @(negedge clk); init_req = 1'b0; init_ack = 1'b0;
        reg_write(8'h02);
        check("R2 after init", reg_rdata, 2);

        // R9: denied read with buffer queued.
        @(negedge clk); tx_empty = 3'b000; win_rd = 1'b1;
        @(negedge clk); win_rd = 1'b0;
        check("R9 blocked queued", win_blocked, 1);
        @(negedge clk);
        check("R9 strobe one cycle", win_blocked, 0);
        // Allowed write: no strobe.
        tx_empty = 3'b010; win_wr = 1'b1;
        @(negedge clk); win_wr = 1'b0;
        check("R9 allowed no strobe", win_blocked, 0);
        // Other buffer free does not help.
        tx_empty = 3'b101; win_wr = 1'b1;
        @(negedge clk); win_wr = 1'b0;
        check("R9 other free blocked", win_blocked, 1);
        // No selection: denied.
        reg_write(8'h00);
        tx_empty = 3'b111; win_rd = 1'b1;
        @(negedge clk); win_rd = 1'b0;
        check("R9 none selected blocked", win_blocked, 1);
        check("R8 none read zero", win_rdata, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule